// File: doc/BRIEF.md
# 100 Mb/s Link-Status Monitor with Recovery

This block decides whether a 100 Mb/s receive path has a usable link. It watches three quality indications: descrambler lock, an SNR-good flag and energy detect. From them it keeps a five-state machine and drives a link-status output and a 3-bit state code. The base path waits for energy, then needs a stable period in which all three indications are good before it declares the link up.

Two optional extensions sit on top of the base path. Both are active while their disable inputs are held low, which is their value after reset.

- **Recovery.** A short loss of any criterion while the link is up sends the machine to a recovery state instead of straight to failure. The link status stays asserted there for a programmable window. If every criterion comes back within that window, the link returns to up with no restart. A failure, by contrast, holds the link down for a fixed time and then restarts establishment from the beginning.
- **Fast link-down.** A per-criterion select mask marks the indications whose loss drops the link to the down state at once.

Top module: `link_watch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the state code is 0 (down) and link status is 0.
- R2: The state codes are down=0, ready=1, up=2, recovery=3, fail=4. Link status is 1 exactly while the state code is 2 or 3.
- R3: In the down state, energy detect high moves the machine to ready on the next clock. In ready, energy detect low moves it back to down on the next clock.
- R4: The machine moves from ready to up once lock, SNR-good and energy have all been high for `stable_cycles` consecutive clocks in ready. Any clock in which one of them is low restarts that count. A setting of 0 behaves as 1.
- R5: In up, with recovery enabled (`recov_off`=0), the loss of any criterion that does not trigger fast link-down moves the machine to recovery on the next clock.
- R6: In recovery, a clock with all criteria good returns the machine to up. If criteria are still missing on the `recov_cycles`-th clock spent in recovery, the machine moves to fail. A setting of 0 behaves as 1.
- R7: With recovery disabled (`recov_off`=1), the loss of any non-fast criterion in up moves the machine straight to fail.
- R8: Fast link-down is active while `fast_off`=0. The mask bits are: bit 0 for lock, bit 1 for SNR-good and bit 2 for energy. While fast link-down is active, losing a criterion whose bit is set moves up directly to down on the next clock, ahead of recovery and fail. With `fast_off`=1 the mask has no effect.
- R9: Fail lasts exactly FAIL_HOLD clocks, whatever the inputs do. The machine then enters down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_lock | input | 1 | Descrambler locked |
| snr_ok | input | 1 | SNR above threshold |
| energy_ok | input | 1 | Energy detected on the line |
| recov_off | input | 1 | 1 disables the recovery state |
| fast_off | input | 1 | 1 disables fast link-down |
| fast_sel | input | 3 | Fast link-down criteria mask (bit0 lock, bit1 SNR, bit2 energy) |
| stable_cycles | input | CW | Consecutive good clocks required in ready |
| recov_cycles | input | CW | Length of the recovery window in clocks |
| link_up | output | 1 | Link status |
| state_code | output | 3 | Current state code |

## Verification
The bench measures the exact clock on which ready becomes up, both for a clean run and for a run with a one-clock lock dropout. A counter that is not cleared by the dropout would report up too early. It lets a recovery window run to its last clock and then one clock further. An off-by-one window would fail a clock early or linger a clock late. It drops an unselected criterion while fast link-down is armed, and a selected one while it is disabled. A design that ignores the mask or the disable would go to down instead of recovery. It also restores all inputs during fail, and the hold must still run its full length.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

  typedef enum logic [2:0] {
    LK_DOWN  = 3'd0,
    LK_READY = 3'd1,
    LK_UP    = 3'd2,
    LK_RECOV = 3'd3,
    LK_FAIL  = 3'd4
  } lk_state_e;

  localparam int NCRIT   = 3;
  localparam int CR_SYNC = 0;
  localparam int CR_SNR  = 1;
  localparam int CR_NRG  = 2;

  // True when a counter that has already seen cnt events reaches the limit
  // with the current event; a zero limit is treated as one.
  function automatic logic limit_reached(input logic [31:0] cnt,
                                         input logic [31:0] lim);
    logic [32:0] eff;
    eff = (lim == 32'd0) ? 33'd1 : {1'b0, lim};
    return ({1'b0, cnt} + 33'd1) >= eff;
  endfunction

  function automatic logic shows_link(input lk_state_e s);
    return (s == LK_UP) || (s == LK_RECOV);
  endfunction

endpackage

// File: rtl/lkm_criteria.sv
module lkm_criteria
  import lkm_pkg::*;
(
  input  logic             desc_lock,
  input  logic             snr_ok,
  input  logic             energy_ok,
  input  logic             fast_off,
  input  logic [NCRIT-1:0] fast_sel,
  output logic [NCRIT-1:0] lost,
  output logic             all_good,
  output logic             fast_hit
);

  logic [NCRIT-1:0] good;
  logic [NCRIT-1:0] fast_vec;

  always_comb begin
    good          = '0;
    good[CR_SYNC] = desc_lock;
    good[CR_SNR]  = snr_ok;
    good[CR_NRG]  = energy_ok;
  end

  for (genvar i = 0; i < NCRIT; i++) begin : g_crit
    assign lost[i]     = ~good[i];
    assign fast_vec[i] = lost[i] & fast_sel[i];
  end

  assign all_good = ~|lost;
  assign fast_hit = ~fast_off & (|fast_vec);

endmodule

// File: rtl/lkm_timer.sv
module lkm_timer
  import lkm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (en && (cnt != {CW{1'b1}})) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = en && limit_reached(32'(cnt), 32'(limit));

endmodule

// File: rtl/link_watch.sv
module link_watch
  import lkm_pkg::*;
#(
  parameter int CW        = 8,
  parameter int FAIL_HOLD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_lock,
  input  logic          snr_ok,
  input  logic          energy_ok,
  input  logic          recov_off,
  input  logic          fast_off,
  input  logic [2:0]    fast_sel,
  input  logic [CW-1:0] stable_cycles,
  input  logic [CW-1:0] recov_cycles,
  output logic          link_up,
  output logic [2:0]    state_code
);

  localparam int HW = $clog2(FAIL_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(FAIL_HOLD);

  lk_state_e state, nxt;

  logic [NCRIT-1:0] lost;
  logic all_good, fast_hit, any_lost;
  logic stab_done, recov_done, fail_done;
  logic in_ready, in_recov, in_fail;
  logic link_q;

  assign in_ready = (state == LK_READY);
  assign in_recov = (state == LK_RECOV);
  assign in_fail  = (state == LK_FAIL);

  lkm_criteria u_crit (
    .desc_lock (desc_lock),
    .snr_ok    (snr_ok),
    .energy_ok (energy_ok),
    .fast_off  (fast_off),
    .fast_sel  (fast_sel),
    .lost      (lost),
    .all_good  (all_good),
    .fast_hit  (fast_hit)
  );

  assign any_lost = |lost;

  // Stabilization: counts consecutive good clocks in ready.
  lkm_timer #(.CW(CW)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_ready || !all_good),
    .en    (in_ready && all_good),
    .limit (stable_cycles),
    .hit   (stab_done)
  );

  // Recovery window: counts clocks spent in recovery without all criteria.
  lkm_timer #(.CW(CW)) u_recov (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_recov),
    .en    (in_recov && !all_good),
    .limit (recov_cycles),
    .hit   (recov_done)
  );

  // Fail hold: fixed dwell before establishment restarts.
  lkm_timer #(.CW(HW)) u_fail (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_fail),
    .en    (in_fail),
    .limit (HOLD_LIM),
    .hit   (fail_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      LK_DOWN:  if (energy_ok) nxt = LK_READY;
      LK_READY: begin
        if (!energy_ok)     nxt = LK_DOWN;
        else if (stab_done) nxt = LK_UP;
      end
      LK_UP: begin
        if (fast_hit)        nxt = LK_DOWN;
        else if (any_lost)   nxt = recov_off ? LK_FAIL : LK_RECOV;
      end
      LK_RECOV: begin
        if (all_good)        nxt = LK_UP;
        else if (recov_done) nxt = LK_FAIL;
      end
      LK_FAIL:  if (fail_done) nxt = LK_DOWN;
      default:  nxt = LK_DOWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= LK_DOWN;
      link_q <= 1'b0;
    end else begin
      state  <= nxt;
      link_q <= shows_link(nxt);
    end
  end

  assign link_up    = link_q;
  assign state_code = state;

endmodule

// File: rtl/link_watch_chk.sv
module link_watch_chk
  import lkm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_code,
  input logic       link_up,
  input logic       energy_ok,
  input logic       recov_off,
  input logic       all_good,
  input logic       any_lost,
  input logic       fast_hit
);

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd4);

  // R2
  link_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up == ((state_code == LK_UP) || (state_code == LK_RECOV)));

  // R3
  down_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_DOWN && energy_ok) |=> state_code == LK_READY);

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_READY && !energy_ok) |=> state_code == LK_DOWN);

  // R4
  ready_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_READY && !all_good) |=> state_code != LK_UP);

  // R5
  up_to_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_UP && any_lost && !fast_hit && !recov_off)
      |=> state_code == LK_RECOV);

  // R6
  recov_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_RECOV && all_good) |=> state_code == LK_UP);

  // R7
  up_to_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_UP && any_lost && !fast_hit && recov_off)
      |=> state_code == LK_FAIL);

  // R8
  fast_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_UP && fast_hit) |=> state_code == LK_DOWN);

  // R9
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == LK_FAIL) |=> (state_code == LK_FAIL || state_code == LK_DOWN));

endmodule

bind link_watch link_watch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_code (state_code),
  .link_up    (link_up),
  .energy_ok  (energy_ok),
  .recov_off  (recov_off),
  .all_good   (all_good),
  .any_lost   (any_lost),
  .fast_hit   (fast_hit)
);

// File: tb/link_watch_bench.sv
module link_watch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int FAIL_HOLD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic desc_lock, snr_ok, energy_ok, recov_off, fast_off;
  logic [2:0] fast_sel;
  logic [CW-1:0] stable_cycles, recov_cycles;
  logic link_up;
  logic [2:0] state_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_watch #(.CW(CW), .FAIL_HOLD(FAIL_HOLD)) u_link_watch (
    .clk(clk), .rst_n(rst_n), .desc_lock(desc_lock), .snr_ok(snr_ok),
    .energy_ok(energy_ok), .recov_off(recov_off), .fast_off(fast_off),
    .fast_sel(fast_sel), .stable_cycles(stable_cycles),
    .recov_cycles(recov_cycles), .link_up(link_up), .state_code(state_code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string req, input logic [2:0] code, input logic lk);
    n_chk++;
    if (state_code !== code || link_up !== lk) begin
      n_bad++;
      $display("FAIL %s: state=%0d link=%0b expected state=%0d link=%0b",
               req, state_code, link_up, code, lk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    desc_lock = 0; snr_ok = 0; energy_ok = 0;
    recov_off = 0; fast_off = 0; fast_sel = 3'b000;
    stable_cycles = 8'd5; recov_cycles = 8'd6;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic bring_up(input int t);
    stable_cycles = CW'(t);
    desc_lock = 1; snr_ok = 1; energy_ok = 1;
    tick(1);
    expect_st("R3 ready", 3'd1, 1'b0);
    tick((t == 0 ? 1 : t) - 1);
    expect_st("R4 still ready", 3'd1, 1'b0);
    tick(1);
    expect_st("R4 up", 3'd2, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    desc_lock = 1; snr_ok = 1; energy_ok = 1;
    tick(1);
    expect_st("R1 in reset", 3'd0, 1'b0);
    do_reset();
    tick(1);
    expect_st("R1 after release", 3'd0, 1'b0);
  endtask

  task automatic t_bringup();
    do_reset();
    tick(1);
    bring_up(5);
  endtask

  task automatic t_dropout();
    do_reset();
    tick(1);
    stable_cycles = 8'd4;
    desc_lock = 1; snr_ok = 1; energy_ok = 1;
    tick(3);
    desc_lock = 0;
    tick(1);
    expect_st("R4 dropout stays ready", 3'd1, 1'b0);
    desc_lock = 1;
    tick(3);
    expect_st("R4 count restarted", 3'd1, 1'b0);
    tick(1);
    expect_st("R4 up after restart", 3'd2, 1'b1);
  endtask

  task automatic t_ready_loss();
    do_reset();
    tick(1);
    energy_ok = 1;
    tick(1);
    expect_st("R3 ready on energy", 3'd1, 1'b0);
    energy_ok = 0;
    tick(1);
    expect_st("R3 down on energy loss", 3'd0, 1'b0);
  endtask

  task automatic t_stable_zero();
    do_reset();
    tick(1);
    bring_up(0);
  endtask

  task automatic t_recover();
    do_reset();
    tick(1);
    bring_up(2);
    snr_ok = 0;
    tick(1);
    expect_st("R5 recovery", 3'd3, 1'b1);
    tick(2);
    expect_st("R6 holding", 3'd3, 1'b1);
    snr_ok = 1;
    tick(1);
    expect_st("R6 back up", 3'd2, 1'b1);
  endtask

  task automatic t_expire();
    do_reset();
    tick(1);
    recov_cycles = 8'd6;
    bring_up(2);
    energy_ok = 0;
    tick(1);
    expect_st("R5 recovery on energy", 3'd3, 1'b1);
    tick(5);
    expect_st("R6 last window clock", 3'd3, 1'b1);
    tick(1);
    expect_st("R6 fail after window", 3'd4, 1'b0);
    desc_lock = 1; snr_ok = 1; energy_ok = 1;
    tick(FAIL_HOLD - 1);
    expect_st("R9 fail held", 3'd4, 1'b0);
    tick(1);
    expect_st("R9 down after hold", 3'd0, 1'b0);
  endtask

  task automatic t_no_recov();
    do_reset();
    recov_off = 1;
    tick(1);
    bring_up(3);
    desc_lock = 0;
    tick(1);
    expect_st("R7 straight to fail", 3'd4, 1'b0);
  endtask

  task automatic t_fast();
    do_reset();
    fast_sel = 3'b001;
    tick(1);
    bring_up(2);
    desc_lock = 0;
    tick(1);
    expect_st("R8 fast down on lock", 3'd0, 1'b0);

    do_reset();
    fast_sel = 3'b001;
    tick(1);
    bring_up(2);
    snr_ok = 0;
    tick(1);
    expect_st("R8 unselected goes recovery", 3'd3, 1'b1);

    do_reset();
    fast_sel = 3'b001;
    fast_off = 1;
    tick(1);
    bring_up(2);
    desc_lock = 0;
    tick(1);
    expect_st("R8 disabled fast ignored", 3'd3, 1'b1);

    do_reset();
    fast_sel = 3'b100;
    recov_off = 1;
    tick(1);
    bring_up(2);
    energy_ok = 0;
    tick(1);
    expect_st("R8 energy fast over fail", 3'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bringup();
    t_dropout();
    t_ready_loss();
    t_stable_zero();
    t_recover();
    t_expire();
    t_no_recov();
    t_fast();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule